// File: doc/BRIEF.md
# Indirect-Target Retraining Sequencer

When an indirect branch resolves to a target the front end did not predict, this block retrains the shared target buffer and direction predictor. The branch is modelled as a chain of virtual conditional branches, and the prediction pass walked that chain. This block walks the same chain again, one virtual branch per cycle. For each virtual branch it presents a probe address to the target buffer and reads back hit, target and use-count in the same cycle. It then issues a direction-training command for that virtual branch.

The walk has two possible outcomes. If some virtual branch already holds the correct target, that link is trained taken and its buffer entry is refreshed, and the walk ends there. If no virtual branch holds the correct target, the walk covers every allowed step. One cycle later the correct target is inserted at a victim link. The victim is the first link that missed in the buffer, or, when none missed, the link with the smallest use-count. A one-cycle completion pulse closes every run.

Top module: `vbt_train_engine`

## Requirements
- R1: Out of reset, `busy`, `done`, `probe_valid`, `dir_wr_valid` and `btb_wr_valid` are all low, and they stay low while idle.
- R2: A `train_go` pulse sampled while idle captures `br_pc`, `fetch_hist` and `true_tgt`. The first probe appears in the next cycle with address equal to the captured PC and history equal to the captured history.
- R3: Probe k (k from 0) uses address PC XOR S(k), where S(k) = (k × 0x9E3779B9) mod 2^AW and AW ≤ 32. Its history is the captured history shifted left by k bits, truncated to HW bits. Probes follow one per cycle.
- R4: A probe that hits with a target equal to the captured correct target gets two commands in that same cycle: a taken direction update (weak=0) and a refresh write (`btb_wr_insert`=0) at the probe address. No further probe follows.
- R5: Every probe that misses, or that hits with a different target, gets a not-taken direction update in its own cycle and no target-buffer write.
- R6: If MAX_ITER probes pass without a correct hit, the cycle right after the last probe carries two commands. One is an insert write (`btb_wr_insert`=1) of the correct target. The other is a taken direction update with `dir_wr_weak`=1, at the same victim address and history.
- R7: The victim is the first probe that missed in the buffer.
- R8: With no miss in the walk, the victim is the probe with the smallest `btb_lfu`. On a tie the earliest such probe wins.
- R9: `done` is high for exactly one cycle, the cycle after the final write. `busy` is high from the cycle after the accepted start through the `done` cycle, and is low afterwards.
- R10: A `train_go` arriving while busy is ignored. The running walk keeps its captured PC, history and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_go | input | 1 | Start a retraining walk |
| br_pc | input | AW | PC of the mispredicted indirect branch |
| fetch_hist | input | HW | Global history captured at fetch |
| true_tgt | input | AW | Resolved correct target |
| probe_valid | output | 1 | A buffer probe is presented this cycle |
| probe_addr | output | AW | Virtual address being probed |
| btb_hit | input | 1 | Probe hit in the target buffer (same cycle) |
| btb_tgt | input | AW | Target stored at the probed entry |
| btb_lfu | input | LW | Use-count of the probed entry |
| dir_wr_valid | output | 1 | Direction-training command valid |
| dir_wr_addr | output | AW | Virtual address to train |
| dir_wr_hist | output | HW | Virtual history to train with |
| dir_wr_taken | output | 1 | Train taken (1) or not-taken (0) |
| dir_wr_weak | output | 1 | Set counter to weakly taken (insertion only) |
| btb_wr_valid | output | 1 | Target-buffer write valid |
| btb_wr_addr | output | AW | Virtual address to write |
| btb_wr_tgt | output | AW | Target to write |
| btb_wr_insert | output | 1 | 1 = new insertion (reset use-count), 0 = refresh (bump use-count) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Probe k's direction command is due k+1 cycles after the start edge. A correct hit is followed one cycle later by `done`. A full miss walk places the insert one cycle after probe MAX_ITER-1 and `done` one cycle after that. The bench precomputes exactly this per-cycle event list for each walk and queues it. A monitor samples on the falling edge and pops one entry for every cycle that shows any command or `done`. An extra, missing or shifted event therefore shows up as a mismatch at the cycle where it occurs. Idle and `busy` checks are taken at fixed offsets after `done`.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

  typedef enum logic [1:0] {
    VB_IDLE = 2'd0,
    VB_SCAN = 2'd1,
    VB_FILL = 2'd2,
    VB_DONE = 2'd3
  } vb_state_e;

  // Per-step address salt: step times an odd constant, low 32 bits.
  function automatic logic [31:0] vb_salt(input logic [31:0] step);
    logic [63:0] prod;
    prod = {32'd0, step} * 64'h0000_0000_9E37_79B9;
    return prod[31:0];
  endfunction

endpackage

// File: rtl/vbt_seq.sv
module vbt_seq #(
  parameter int AW = 32,
  parameter int HW = 16,
  parameter int IW = 2
) (
  input  logic [AW-1:0] base_pc,
  input  logic [HW-1:0] base_hist,
  input  logic [IW-1:0] step,
  output logic [AW-1:0] v_addr,
  output logic [HW-1:0] v_hist
);
  import vbt_pkg::*;

  logic [31:0] salt;

  assign salt   = vb_salt(32'(step));
  assign v_addr = base_pc ^ salt[AW-1:0];
  assign v_hist = base_hist << step;

endmodule

// File: rtl/vbt_ctrl.sv
module vbt_ctrl #(
  parameter int MAX_ITER = 4,
  parameter int IW       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               hit_ok,
  output vbt_pkg::vb_state_e state,
  output logic [IW-1:0]      step,
  output logic               last_step
);
  import vbt_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(MAX_ITER - 1);

  assign last_step = (step == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= VB_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        VB_IDLE: if (go) begin
          state <= VB_SCAN;
          step  <= '0;
        end
        VB_SCAN: begin
          if (hit_ok)         state <= VB_DONE;
          else if (last_step) state <= VB_FILL;
          else                step  <= step + 1'b1;
        end
        VB_FILL: state <= VB_DONE;
        VB_DONE: state <= VB_IDLE;
        default: state <= VB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vbt_victim.sv
module vbt_victim #(
  parameter int AW = 32,
  parameter int HW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic          miss,
  input  logic [AW-1:0] v_addr,
  input  logic [HW-1:0] v_hist,
  input  logic [LW-1:0] lfu,
  output logic [AW-1:0] cand_addr,
  output logic [HW-1:0] cand_hist
);
  logic          have_miss, have_any;
  logic [LW-1:0] cand_lfu;
  logic          take;

  // First miss locks the choice; otherwise a strictly smaller count wins.
  assign take = sample && !have_miss && (miss || !have_any || (lfu < cand_lfu));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_miss <= 1'b0;
      have_any  <= 1'b0;
      cand_lfu  <= '0;
      cand_addr <= '0;
      cand_hist <= '0;
    end else if (clear) begin
      have_miss <= 1'b0;
      have_any  <= 1'b0;
    end else begin
      if (sample) have_any <= 1'b1;
      if (take) begin
        cand_addr <= v_addr;
        cand_hist <= v_hist;
        cand_lfu  <= lfu;
        if (miss) have_miss <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vbt_train_engine.sv
module vbt_train_engine #(
  parameter int AW       = 32,
  parameter int HW       = 16,
  parameter int LW       = 2,
  parameter int MAX_ITER = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          train_go,
  input  logic [AW-1:0] br_pc,
  input  logic [HW-1:0] fetch_hist,
  input  logic [AW-1:0] true_tgt,
  output logic          probe_valid,
  output logic [AW-1:0] probe_addr,
  input  logic          btb_hit,
  input  logic [AW-1:0] btb_tgt,
  input  logic [LW-1:0] btb_lfu,
  output logic          dir_wr_valid,
  output logic [AW-1:0] dir_wr_addr,
  output logic [HW-1:0] dir_wr_hist,
  output logic          dir_wr_taken,
  output logic          dir_wr_weak,
  output logic          btb_wr_valid,
  output logic [AW-1:0] btb_wr_addr,
  output logic [AW-1:0] btb_wr_tgt,
  output logic          btb_wr_insert,
  output logic          busy,
  output logic          done
);
  import vbt_pkg::*;

  localparam int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

  vb_state_e     state;
  logic [IW-1:0] step;
  logic          last_step;
  logic [AW-1:0] pc_q, tgt_q, v_addr, cand_addr;
  logic [HW-1:0] hist_q, v_hist, cand_hist;

  // Named internal events
  logic accept_go, in_scan, in_fill, hit_ok, probe_wrong;

  assign accept_go   = train_go && (state == VB_IDLE);
  assign in_scan     = (state == VB_SCAN);
  assign in_fill     = (state == VB_FILL);
  assign hit_ok      = in_scan && btb_hit && (btb_tgt == tgt_q);
  assign probe_wrong = in_scan && !hit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      hist_q <= '0;
      tgt_q  <= '0;
    end else if (accept_go) begin
      pc_q   <= br_pc;
      hist_q <= fetch_hist;
      tgt_q  <= true_tgt;
    end
  end

  vbt_ctrl #(.MAX_ITER(MAX_ITER), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(accept_go), .hit_ok(hit_ok),
    .state(state), .step(step), .last_step(last_step)
  );

  vbt_seq #(.AW(AW), .HW(HW), .IW(IW)) u_seq (
    .base_pc(pc_q), .base_hist(hist_q), .step(step),
    .v_addr(v_addr), .v_hist(v_hist)
  );

  vbt_victim #(.AW(AW), .HW(HW), .LW(LW)) u_victim (
    .clk(clk), .rst_n(rst_n), .clear(accept_go), .sample(probe_wrong),
    .miss(!btb_hit), .v_addr(v_addr), .v_hist(v_hist), .lfu(btb_lfu),
    .cand_addr(cand_addr), .cand_hist(cand_hist)
  );

  assign probe_valid   = in_scan;
  assign probe_addr    = v_addr;

  assign dir_wr_valid  = in_scan || in_fill;
  assign dir_wr_addr   = in_fill ? cand_addr : v_addr;
  assign dir_wr_hist   = in_fill ? cand_hist : v_hist;
  assign dir_wr_taken  = hit_ok || in_fill;
  assign dir_wr_weak   = in_fill;

  assign btb_wr_valid  = hit_ok || in_fill;
  assign btb_wr_addr   = dir_wr_addr;
  assign btb_wr_tgt    = tgt_q;
  assign btb_wr_insert = in_fill;

  assign busy = (state != VB_IDLE);
  assign done = (state == VB_DONE);

  // ---------------- assertions ----------------
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!probe_valid && !dir_wr_valid && !btb_wr_valid && !done));

  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && $past(probe_valid)) |-> (dir_wr_hist == ($past(dir_wr_hist) << 1)));

  assert_refresh_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (btb_wr_valid && !btb_wr_insert) |=> (done && !probe_valid));

  assert_nt_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr_valid && !dir_wr_taken) |-> (probe_valid && !btb_wr_valid));

  assert_fill_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (btb_wr_valid && btb_wr_insert) |=> done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/tb_vbt_train_engine.sv
module tb_vbt_train_engine;
  localparam int AW = 32, HW = 16, LW = 2, NI = 4;

  typedef struct packed {
    logic dv; logic [AW-1:0] da; logic [HW-1:0] dh; logic dt; logic dw;
    logic bv; logic [AW-1:0] ba; logic [AW-1:0] bt; logic bi; logic dn;
  } ev_t;

  logic clk = 0, rst_n = 0, train_go = 0;
  logic [AW-1:0] br_pc = '0, true_tgt = '0;
  logic [HW-1:0] fetch_hist = '0;
  logic probe_valid; logic [AW-1:0] probe_addr;
  logic btb_hit; logic [AW-1:0] btb_tgt; logic [LW-1:0] btb_lfu;
  logic dir_wr_valid, dir_wr_taken, dir_wr_weak;
  logic [AW-1:0] dir_wr_addr; logic [HW-1:0] dir_wr_hist;
  logic btb_wr_valid, btb_wr_insert; logic [AW-1:0] btb_wr_addr, btb_wr_tgt;
  logic busy, done;

  int total = 0, bad = 0;
  ev_t q[$];
  string cur_req = "R1";

  // Bench-side target buffer script, keyed by probe index
  logic [AW-1:0] run_pc;
  logic          sc_hit [NI];
  logic [AW-1:0] sc_tgt [NI];
  logic [LW-1:0] sc_lfu [NI];

  always #2 clk = ~clk;  // 250 MHz

  vbt_train_engine #(.AW(AW), .HW(HW), .LW(LW), .MAX_ITER(NI)) dut (.*);

  // R3: address salt as repeated addition of the constant
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] pc, input int k);
    logic [31:0] acc = 32'd0;
    for (int i = 0; i < k; i++) acc = acc + 32'h9E37_79B9;
    return pc ^ acc;
  endfunction

  function automatic logic [HW-1:0] exp_hist(input logic [HW-1:0] h, input int k);
    logic [HW-1:0] r = h;
    for (int i = 0; i < k; i++) r = {r[HW-2:0], 1'b0};
    return r;
  endfunction

  always_comb begin
    btb_hit = 1'b0; btb_tgt = '0; btb_lfu = '0;
    for (int k = 0; k < NI; k++)
      if (probe_valid && probe_addr == exp_addr(run_pc, k)) begin
        btb_hit = sc_hit[k]; btb_tgt = sc_tgt[k]; btb_lfu = sc_lfu[k];
      end
  end

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Monitor: pop one expected item per cycle that shows any event
  always @(negedge clk) begin
    if (rst_n && (dir_wr_valid || btb_wr_valid || done)) begin
      ev_t g;
      g = '0;
      g.dv = dir_wr_valid; g.bv = btb_wr_valid; g.dn = done;
      if (dir_wr_valid) begin g.da = dir_wr_addr; g.dh = dir_wr_hist; g.dt = dir_wr_taken; g.dw = dir_wr_weak; end
      if (btb_wr_valid) begin g.ba = btb_wr_addr; g.bt = btb_wr_tgt; g.bi = btb_wr_insert; end
      if (q.size() == 0) check({cur_req, " unexpected"}, 256'(g), 256'(0));
      else check(cur_req, 256'(g), 256'(q.pop_front()));
    end
  end

  // Driver: compute expected event list, then start the walk
  task automatic run_case(input string req, input logic [AW-1:0] pc, input logic [HW-1:0] h,
                          input logic [AW-1:0] tgt, input int stray_at);
    ev_t e; logic [AW-1:0] ca; logic [HW-1:0] ch; logic [LW-1:0] cl;
    bit found = 0, have_miss = 0;
    cur_req = req;
    run_pc = pc; ca = '0; ch = '0; cl = '0;
    for (int k = 0; k < NI && !found; k++) begin
      e = '0;
      e.dv = 1; e.da = exp_addr(pc, k); e.dh = exp_hist(h, k);
      if (sc_hit[k] && sc_tgt[k] == tgt) begin       // R4
        e.dt = 1; e.bv = 1; e.ba = e.da; e.bt = tgt; e.bi = 0;
        found = 1;
      end else begin                                  // R5, R7, R8
        if (!have_miss && (!sc_hit[k] || k == 0 || sc_lfu[k] < cl)) begin
          ca = e.da; ch = e.dh; cl = sc_lfu[k];
          if (!sc_hit[k]) have_miss = 1;
        end
      end
      q.push_back(e);
    end
    if (!found) begin                                  // R6
      e = '0;
      e.dv = 1; e.da = ca; e.dh = ch; e.dt = 1; e.dw = 1;
      e.bv = 1; e.ba = ca; e.bt = tgt; e.bi = 1;
      q.push_back(e);
    end
    e = '0; e.dn = 1; q.push_back(e);                 // R9
    @(negedge clk);
    br_pc = pc; fetch_hist = h; true_tgt = tgt; train_go = 1;
    @(negedge clk);
    train_go = 0; br_pc = ~pc; fetch_hist = ~h; true_tgt = ~tgt;
    check("R9 busy after start", 256'(busy), 256'(1));
    if (stray_at >= 0) begin                           // R10
      repeat (stray_at) @(negedge clk);
      train_go = 1; br_pc = pc + 32'h100; true_tgt = 32'hDEAD_0000;
      @(negedge clk);
      train_go = 0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check({req, " R9 idle after done"}, 256'({busy, done}), 256'(0));
    repeat (2) @(negedge clk);
  endtask

  task automatic set_probe(input int k, input logic h, input logic [AW-1:0] t, input logic [LW-1:0] l);
    sc_hit[k] = h; sc_tgt[k] = t; sc_lfu[k] = l;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_pc = '0;
    for (int k = 0; k < NI; k++) set_probe(k, 0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 256'(busy), 256'(0));
    check("R1 done", 256'(done), 256'(0));
    check("R1 cmds", 256'({probe_valid, dir_wr_valid, btb_wr_valid}), 256'(0));

    // R2 R4: correct target at the very first probe
    for (int k = 0; k < NI; k++) set_probe(k, 1, 32'h1000_0000 + k, 2'd1);
    run_case("R2_R4 first", 32'h0040_1230, 16'hA5C3, 32'h1000_0000, -1);

    // R3 R4 R5: correct target at probe 2
    run_case("R3_R5 mid", 32'h0080_0004, 16'h8001, 32'h1000_0002, -1);

    // R4: correct target at the last probe
    run_case("R4 last", 32'h00C0_FFF0, 16'h1234, 32'h1000_0003, -1);

    // R6 R7: no correct target, misses at probes 1 and 3
    set_probe(0, 1, 32'h2000_0000, 2'd0);
    set_probe(1, 0, '0, 2'd3);
    set_probe(2, 1, 32'h2000_0002, 2'd0);
    set_probe(3, 0, '0, 2'd0);
    run_case("R6_R7 miss1", 32'h0100_0010, 16'hF00F, 32'h3333_0000, -1);

    // R7: miss at probe 0 gives PC and fetch history
    set_probe(0, 0, '0, 2'd0);
    run_case("R7 miss0", 32'h0200_0020, 16'h0F0F, 32'h4444_0000, -1);

    // R8: all hit wrong, counts 2,1,3,1 -> probe 1 wins the tie
    set_probe(0, 1, 32'h5000_0000, 2'd2);
    set_probe(1, 1, 32'h5000_0001, 2'd1);
    set_probe(2, 1, 32'h5000_0002, 2'd3);
    set_probe(3, 1, 32'h5000_0003, 2'd1);
    run_case("R8 lfu", 32'h0300_0030, 16'h7E57, 32'h6666_0000, -1);

    // R8: smallest count at the final probe
    set_probe(3, 1, 32'h5000_0003, 2'd0);
    run_case("R8 lfu_last", 32'h0310_0030, 16'h0001, 32'h6666_0001, -1);

    // R10: stray start mid-walk is ignored
    set_probe(0, 1, 32'h2000_0000, 2'd0);
    set_probe(1, 0, '0, 2'd3);
    run_case("R10 stray", 32'h0400_0040, 16'hC0DE, 32'h7777_0000, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule